// File: doc/BRIEF.md
# Taken-Branch Instruction Pair Cache

This block is a small fully associative store that hides part of the refetch delay that follows a taken branch. Each entry keeps the first two instructions found at a branch target, filed under the logical address of the branch. When the front end resolves a taken branch and has fetched the two target instructions, it presents them on the fill port. When a taken branch at a known address is met again, the front end presents that address on the lookup port. One cycle later the block returns the cached pair so the issue queue can be loaded at once, without waiting for the instruction cache.

Fills go to a free entry. The search for a free entry starts at a pseudo-random index taken from a free-running LFSR and moves upward, wrapping at the top. When every entry is valid, the entry at the LFSR index is replaced. A fill whose tag is already present rewrites that entry in place. A global flush input drops every entry in a single cycle, for example on a context switch.

Top module: `brtgt_cache`

## Requirements
- R1: After reset every entry is invalid, and the outputs are hit low with both instruction words zero.
- R2: A lookup whose tag matches a valid entry drives hit high in the following cycle, with the entry's first instruction on insn0 and its second instruction on insn1.
- R3: In the cycle after a missed lookup, or after a cycle with no lookup, hit is low and both instruction words are zero.
- R4: A fill writes its tag and instruction pair into an entry and marks that entry valid. While a free entry exists, no valid entry is displaced, so up to ENTRIES distinct tags are all retained.
- R5: A fill whose tag matches a valid entry overwrites that entry's instructions and does not allocate a second entry, so a tag is never held twice.
- R6: When all entries are valid, a fill with a new tag replaces exactly one existing entry, and every other entry is kept.
- R7: A flush clears every valid bit at the next clock edge. A fill in the same cycle as a flush is discarded.
- R8: A lookup and a fill in the same cycle see the contents from before the fill. A new tag misses, and an overwritten tag returns its old pair.
- R9: The fill entry is the first free entry at or after the LFSR index, wrapping past the top. The LFSR advances every cycle and never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate every entry |
| fill_en | input | 1 | Write a branch tag and target instruction pair |
| fill_tag | input | TAG_W | Logical address tag of the taken branch |
| fill_insn0 | input | INSN_W | First instruction at the target |
| fill_insn1 | input | INSN_W | Second instruction at the target |
| look_en | input | 1 | Look up a taken branch |
| look_tag | input | TAG_W | Logical address tag to look up |
| hit | output | 1 | Registered lookup hit |
| insn0 | output | INSN_W | Registered first cached instruction, zero when no hit |
| insn1 | output | INSN_W | Registered second cached instruction, zero when no hit |

## Verification
The first pattern is a sequential fill of exactly ENTRIES distinct tags. Every tag must still hit afterwards, which shows that the fill goes only to free entries whatever the LFSR index is. A fill with one more tag must then lose exactly one of the old tags, which separates victim replacement from a fill that is dropped or one that clears more than one entry. Repeated fills of one tag followed by a near-full load show whether an overwrite takes a second entry. Same-cycle lookup and fill, and fill together with flush, separate the read-before-write ordering and the flush priority. A long random mix over a tag pool smaller than the cache is compared against an exact model on every cycle.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  // Galois feedback mask for a 16-bit maximal-length LFSR
  localparam logic [15:0] LFSR16_TAPS = 16'hB400;
  localparam logic [15:0] LFSR16_SEED = 16'h0001;
endpackage

// File: rtl/brtgt_lfsr.sv
module brtgt_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = brtgt_pkg::LFSR16_TAPS,
  parameter logic [W-1:0] SEED = brtgt_pkg::LFSR16_SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_d;

  always_comb begin
    state_d = {1'b0, state_o[W-1:1]};
    if (state_o[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= SEED;
    else        state_o <= state_d;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != '0); // R9
  AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state_o != $past(state_o)); // R9
endmodule

// File: rtl/brtgt_tag_match.sv
module brtgt_tag_match #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 30
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]              look_tag_i,
  input  logic [TAG_W-1:0]              fill_tag_i,
  output logic [ENTRIES-1:0]            look_vec_o,
  output logic [ENTRIES-1:0]            fill_vec_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign look_vec_o[e] = valid_i[e] && (tags_i[e] == look_tag_i);
    assign fill_vec_o[e] = valid_i[e] && (tags_i[e] == fill_tag_i);
  end
endmodule

// File: rtl/brtgt_victim_pick.sv
module brtgt_victim_pick #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   start_i,
  output logic               any_free_o,
  output logic [IDX_W-1:0]   pick_o
);
  always_comb begin
    any_free_o = ~&valid_i;
    pick_o     = start_i;
    // walk offsets from far to near so the nearest free entry wins
    for (int off = ENTRIES - 1; off >= 0; off--) begin
      int slot;
      slot = (int'(start_i) + off) % ENTRIES;
      if (!valid_i[slot]) pick_o = IDX_W'(slot);
    end
  end
endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 30,
  parameter int INSN_W  = 32,
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = brtgt_pkg::LFSR16_TAPS,
  parameter logic [LFSR_W-1:0] LFSR_SEED = brtgt_pkg::LFSR16_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [INSN_W-1:0] fill_insn0,
  input  logic [INSN_W-1:0] fill_insn1,
  input  logic              look_en,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              hit,
  output logic [INSN_W-1:0] insn0,
  output logic [INSN_W-1:0] insn1
);
  localparam int IDX_W = $clog2(ENTRIES);

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_pipe;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  // storage
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [INSN_W-1:0]             ins0_q [ENTRIES];
  logic [INSN_W-1:0]             ins1_q [ENTRIES];

  logic [ENTRIES-1:0] look_vec, fill_vec;
  logic               look_any, fill_any, any_free, wr_en;
  logic [IDX_W-1:0]   look_idx, fill_idx, pick_idx, rnd_idx, wr_idx;
  logic [LFSR_W-1:0]  lfsr_state;
  logic               hit_d;
  logic [INSN_W-1:0]  insn0_d, insn1_d;

  brtgt_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_ok),
    .state_o (lfsr_state)
  );
  assign rnd_idx = lfsr_state[IDX_W-1:0];

  brtgt_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
    .valid_i    (valid_q),
    .tags_i     (tag_q),
    .look_tag_i (look_tag),
    .fill_tag_i (fill_tag),
    .look_vec_o (look_vec),
    .fill_vec_o (fill_vec)
  );

  brtgt_victim_pick #(.ENTRIES(ENTRIES)) u_pick (
    .valid_i    (valid_q),
    .start_i    (rnd_idx),
    .any_free_o (any_free),
    .pick_o     (pick_idx)
  );

  // one-hot to index
  always_comb begin
    look_idx = '0;
    fill_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (look_vec[e]) look_idx = look_idx | IDX_W'(e);
      if (fill_vec[e]) fill_idx = fill_idx | IDX_W'(e);
    end
    look_any = |look_vec;
    fill_any = |fill_vec;
  end

  // fill target: existing copy, else free slot, else LFSR victim
  always_comb begin
    wr_en = fill_en && !flush;
    if (fill_any)      wr_idx = fill_idx;
    else if (any_free) wr_idx = pick_idx;
    else               wr_idx = rnd_idx;
  end

  always_comb begin
    valid_d = valid_q;
    if (flush)      valid_d = '0;
    else if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  // lookup result reads state from before this cycle's fill
  always_comb begin
    hit_d   = look_en && look_any;
    insn0_d = hit_d ? ins0_q[look_idx] : '0;
    insn1_d = hit_d ? ins1_q[look_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      valid_q <= '0;
      hit     <= 1'b0;
      insn0   <= '0;
      insn1   <= '0;
    end else begin
      valid_q <= valid_d;
      hit     <= hit_d;
      insn0   <= insn0_d;
      insn1   <= insn1_d;
    end
  end

  // payload arrays carry no reset; valid bits gate them
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= fill_tag;
      ins0_q[wr_idx] <= fill_insn0;
      ins1_q[wr_idx] <= fill_insn1;
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_ok)
    flush |=> (valid_q == '0)); // R7
  AST_HIT_NEEDS_LOOK: assert property (@(posedge clk) disable iff (!rst_ok)
    hit |-> $past(look_en)); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    !hit |-> (insn0 == '0 && insn1 == '0)); // R3
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_en |=> valid_q[$past(wr_idx)]); // R4
  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(look_vec) && $onehot0(fill_vec)); // R5
  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_ok)
    (&valid_q && !flush) |=> &valid_q); // R6
  AST_PICK_FREE: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && !fill_any && any_free) |-> !valid_q[pick_idx]); // R9
endmodule

// File: tb/brtgt_cache_test.sv
module brtgt_cache_test;
  localparam int N  = 32;
  localparam int TW = 30;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush, fill_en, look_en;
  logic [TW-1:0] fill_tag, look_tag;
  logic [IW-1:0] fill_insn0, fill_insn1;
  logic          hit;
  logic [IW-1:0] insn0, insn1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  brtgt_cache uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fill_en(fill_en), .fill_tag(fill_tag),
    .fill_insn0(fill_insn0), .fill_insn1(fill_insn1),
    .look_en(look_en), .look_tag(look_tag),
    .hit(hit), .insn0(insn0), .insn1(insn1)
  );

  // reference model: unordered list of held tags (exact while not full)
  logic [TW-1:0] m_tag [N];
  logic [IW-1:0] m_d0  [N];
  logic [IW-1:0] m_d1  [N];
  int            m_n;

  function automatic int m_find(logic [TW-1:0] t);
    for (int i = 0; i < m_n; i++) if (m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic void m_fill(logic [TW-1:0] t, logic [IW-1:0] a, logic [IW-1:0] b);
    int k;
    k = m_find(t);
    if (k < 0 && m_n < N) begin k = m_n; m_n++; end
    if (k >= 0) begin m_tag[k] = t; m_d0[k] = a; m_d1[k] = b; end
  endfunction

  task automatic check(string req, string what, logic [IW-1:0] act, logic [IW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic          r_hit;
  logic [IW-1:0] r_d0, r_d1;

  // one clock: drive at negedge, sample at the following negedge
  task automatic cyc(bit u, logic [TW-1:0] ut, logic [IW-1:0] a, logic [IW-1:0] b,
                     bit l, logic [TW-1:0] lt, bit iv, bit chk, string req);
    int      k;
    bit      eh;
    logic [IW-1:0] e0, e1;
    fill_en = u; fill_tag = ut; fill_insn0 = a; fill_insn1 = b;
    look_en = l; look_tag = lt; flush = iv;
    k  = l ? m_find(lt) : -1;
    eh = (k >= 0);
    e0 = eh ? m_d0[k] : '0;
    e1 = eh ? m_d1[k] : '0;
    @(posedge clk);
    @(negedge clk);
    r_hit = hit; r_d0 = insn0; r_d1 = insn1;
    if (chk) begin
      check(req, "hit",   {31'b0, hit}, {31'b0, eh});
      check(req, "insn0", insn0, e0);
      check(req, "insn1", insn1, e1);
    end
    if (iv) m_n = 0;
    else if (u) m_fill(ut, a, b);
  endtask

  task automatic idle();
    cyc(0, '0, '0, '0, 0, '0, 0, 0, "");
  endtask

  // watchdog
  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL all watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    int lost;
    seed = 7;
    void'($urandom(seed));
    m_n = 0;
    rst_n = 1'b0;
    flush = 0; fill_en = 0; look_en = 0;
    fill_tag = '0; look_tag = '0; fill_insn0 = '0; fill_insn1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    check("R1", "hit in reset", {31'b0, hit}, 32'd0);
    check("R1", "insn0 in reset", insn0, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: nothing valid after reset
    for (int i = 0; i < 4; i++)
      cyc(0, '0, '0, '0, 1, TW'(i * 17), 0, 1, "R1");

    // R4 R9: fill exactly N distinct tags, all retained
    for (int i = 0; i < N; i++)
      cyc(1, TW'(1000 + i), $urandom, $urandom, 0, '0, 0, 0, "");
    for (int i = 0; i < N; i++)
      cyc(0, '0, '0, '0, 1, TW'(1000 + i), 0, 1, "R4 R9 fill retained");

    // R6: one more tag replaces exactly one entry
    cyc(1, TW'(2000), 32'hCAFE0001, 32'hCAFE0002, 0, '0, 0, 0, "");
    cyc(0, '0, '0, '0, 1, TW'(2000), 0, 0, "");
    check("R6", "new tag hit", {31'b0, r_hit}, 32'd1);
    check("R6", "new tag insn0", r_d0, 32'hCAFE0001);
    check("R6", "new tag insn1", r_d1, 32'hCAFE0002);
    lost = 0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = m_find(TW'(1000 + i));
      cyc(0, '0, '0, '0, 1, TW'(1000 + i), 0, 0, "");
      if (!r_hit) lost++;
      else begin
        check("R6", "kept insn0", r_d0, m_d0[k]);
        check("R6", "kept insn1", r_d1, m_d1[k]);
      end
    end
    check("R6", "entries lost", lost, 32'd1);

    // R7: flush with a fill in the same cycle
    cyc(1, TW'(3000), 32'h1, 32'h2, 0, '0, 1, 0, "");
    cyc(0, '0, '0, '0, 1, TW'(3000), 0, 1, "R7 fill with flush");
    cyc(0, '0, '0, '0, 1, TW'(1005), 0, 1, "R7 old tag gone");
    cyc(0, '0, '0, '0, 1, TW'(2000), 0, 1, "R7 new tag gone");

    // R8: same-cycle lookup and fill
    cyc(1, TW'(4000), 32'hA0, 32'hA1, 1, TW'(4000), 0, 1, "R8 new tag misses");
    cyc(1, TW'(4000), 32'hB0, 32'hB1, 1, TW'(4000), 0, 1, "R8 old pair seen");
    cyc(0, '0, '0, '0, 1, TW'(4000), 0, 1, "R8 R2 new pair after");

    // R5: repeated fills of one tag, then load up to full
    cyc(1, TW'(4000), 32'hC0, 32'hC1, 0, '0, 0, 0, "");
    for (int i = 0; i < N - 1; i++)
      cyc(1, TW'(4100 + i), $urandom, $urandom, 0, '0, 0, 0, "");
    cyc(0, '0, '0, '0, 1, TW'(4000), 0, 1, "R5 overwrite kept");
    for (int i = 0; i < N - 1; i++)
      cyc(0, '0, '0, '0, 1, TW'(4100 + i), 0, 1, "R5 no duplicate");
    cyc(0, '0, '0, '0, 1, TW'(77), 0, 1, "R3 miss");

    // random mix over a pool smaller than the cache
    cyc(0, '0, '0, '0, 0, '0, 1, 0, "");
    for (int n = 0; n < 4000; n++) begin
      bit u, l, iv;
      u  = ($urandom % 2) == 0;
      l  = ($urandom % 2) == 0;
      iv = ($urandom % 64) == 0;
      cyc(u, TW'(5000 + $urandom % 20), $urandom, $urandom,
          l, TW'(5000 + $urandom % 24), iv, 1, "R2 R3 R5 R7 R8 random");
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule